// File: doc/BRIEF.md
# Serial EEPROM Paged Word Writer

This block is a hardware SPI master that stores a run of 16-bit words in a serial EEPROM, starting at a chosen word index. A single start pulse supplies the first word index and the number of words. The words then arrive on a valid/ready stream, and the block turns them into the command frames the memory expects. It checks the request against the device size before it touches the bus. An illegal request finishes at once with an error, and the chip select stays high throughout.

The memory takes data one page at a time, so the block splits the run into bursts. Each burst ends at a page boundary or at the last word. Every burst follows the same sequence:

1. Poll the memory's status byte until the busy flag is clear, up to a fixed number of tries.
2. Send a write-enable frame.
3. Send a write frame with an opcode, a byte address and the data, with each word's bytes swapped.
4. Raise the chip select and hold it high for the programmed write-cycle time.

When the last burst is complete, the block pulses its done output. An error flag comes with that pulse. Page size, address width, retry budget, write-cycle time and SCK half-period are all parameters.

Top module: `eeprom_page_writer`

## Requirements
- R1: A request finishes with done and error one cycle after start, with no chip-select activity, when the word index is at or beyond DEV_WORDS, when the count is zero, or when the count exceeds DEV_WORDS minus the index.
- R2: Each burst begins with a status frame. The frame holds opcode 0x05 followed by 8 clocks with MOSI low, during which the memory returns its status byte MSB first. Only bit 0 (busy) is examined. The block moves on once bit 0 reads zero.
- R3: While bit 0 reads one, the block raises chip select for one half-period and polls again. When RETRY_MAX polls have all read busy, the block raises chip select and signals done with error.
- R4: Write-enable (opcode 0x06) is sent as its own 8-bit frame. It is placed between the successful status frame and the write frame, and a chip-select pulse separates it from each of them.
- R5: The write opcode is 0x02. When ADDR_BITS is 8 and the word index of the burst's first word is 128 or more, the opcode also carries bit 3 (0x0A).
- R6: The address follows the opcode MSB first over ADDR_BITS bits. Its value is twice the word index of the burst's first word, truncated to ADDR_BITS bits.
- R7: Each word is sent as 16 bits, bits 7..0 first and then bits 15..8, each byte MSB first.
- R8: A burst ends after the word that makes the next byte address a multiple of PAGE_BYTES, or after the last word. Any remaining words start a fresh burst with its own status poll and write-enable.
- R9: The bus runs in SPI mode 0. MOSI changes only while SCK is low, and SCK is low whenever chip select changes. MOSI is low when chip select rises.
- R10: After every write frame, chip select stays high for at least WCYC_CLKS cycles before the next frame starts or done is signalled.
- R11: Done is a one-cycle pulse, with error low after a successful run. Ready is asserted only to take a word inside a write frame, so exactly the requested number of words is consumed. In idle, chip select is high and SCK, MOSI, done and ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken in idle |
| offset_i | input | OFF_W | First word index |
| count_i | input | CNT_W | Number of words to write |
| wdata_i | input | 16 | Word stream data |
| wvalid_i | input | 1 | Word stream valid |
| wready_o | output | 1 | Word stream ready |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the memory |
| spi_miso_i | input | 1 | Serial data from the memory |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error flag, valid with done |

## Verification
The bench models the memory at the pins and compares every frame, bit for bit, against a frame list it computes from the requirements. The index sweep crosses zero, the page edges at 7/8, the 127/128 split where the high address bit moves into the opcode, and the last device words. Each index is combined with counts of 0, 1, 2, 8, 9 and 17 words, which separates single-word bursts, exact pages and page splits from runs that cross the device end and are rejected. Separate runs answer busy for 1, 2, 3 and 5 polls, which places the retry limit exactly. In the ready status the upper bits are set, which shows that only bit 0 matters.

// File: rtl/epw_pkg.sv
// Shared opcodes and state encodings for the paged EEPROM writer.
// Assumes 8-bit opcodes; wider opcode fields zero-extend these values.
package epw_pkg;
    localparam logic [7:0] EPW_OP_WRITE   = 8'h02;
    localparam logic [7:0] EPW_OP_WREN    = 8'h06;
    localparam logic [7:0] EPW_OP_STATUS  = 8'h05;
    localparam logic [7:0] EPW_OP_HI_ADDR = 8'h08;

    typedef enum logic [2:0] {
        S_IDLE, S_POLL, S_GAP, S_WREN, S_WRCMD, S_WAIT_W, S_DATA, S_WCYC
    } epw_state_e;

    typedef enum logic [1:0] {
        K_POLL, K_WREN, K_WRCMD
    } epw_cmd_e;
endpackage

// File: rtl/epw_range_check.sv
// Request bounds check: the run must start inside the device, hold at least
// one word and end no later than the device's last word.
// Assumes DEV_WORDS fits in 32 bits.
module epw_range_check #(
    parameter int DEV_WORDS = 256,
    parameter int OFF_W     = 10,
    parameter int CNT_W     = 10
) (
    input  logic [OFF_W-1:0] offset_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             ok_o
);
    logic [31:0] off32, cnt32;

    // Widen both operands so the comparisons cannot wrap.
    always_comb begin
        off32 = 32'(offset_i);
        cnt32 = 32'(count_i);
        ok_o  = (off32 < 32'(DEV_WORDS)) && (cnt32 != 32'd0) &&
                (cnt32 <= (32'(DEV_WORDS) - off32));
    end
endmodule

// File: rtl/epw_shift_engine.sv
// SPI mode-0 bit engine. It shifts out the low nbits of dout MSB first and
// samples MISO on each falling SCK edge. Each bit takes HALF_CLKS cycles with
// SCK low (data set up), then HALF_CLKS cycles with SCK high. MOSI rests low.
// Assumes go_i is raised only while the engine is idle.
module epw_shift_engine #(
    parameter int XFER_W    = 16,
    parameter int HALF_CLKS = 1,
    localparam int NB_W     = $clog2(XFER_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [NB_W-1:0]   nbits_i,
    input  logic [XFER_W-1:0] dout_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              fin_o,
    output logic [7:0]        din_o,
    output logic              sck_o,
    output logic              mosi_o
);
    localparam int HT_W = $clog2(HALF_CLKS + 1);

    logic [XFER_W-1:0] sreg, aligned;
    logic [NB_W-1:0]   left;
    logic [HT_W-1:0]   tmr;
    logic              phase_hi;

    // Move the first bit to the top of the shift register.
    assign aligned = dout_i << (NB_W'(XFER_W) - nbits_i);

    // Sequence half-periods, shift out and sample in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0; fin_o <= 1'b0; sck_o <= 1'b0; mosi_o <= 1'b0;
            sreg <= '0; din_o <= '0; left <= '0; tmr <= '0; phase_hi <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (!busy_o) begin
                if (go_i) begin
                    busy_o   <= 1'b1;
                    sreg     <= aligned;
                    mosi_o   <= aligned[XFER_W-1];
                    din_o    <= '0;
                    left     <= nbits_i;
                    tmr      <= '0;
                    phase_hi <= 1'b0;
                end
            end else if (tmr != HT_W'(HALF_CLKS - 1)) begin
                tmr <= tmr + 1'b1;
            end else begin
                tmr <= '0;
                if (!phase_hi) begin
                    sck_o    <= 1'b1;
                    phase_hi <= 1'b1;
                end else begin
                    sck_o    <= 1'b0;
                    phase_hi <= 1'b0;
                    din_o    <= {din_o[6:0], miso_i};
                    left     <= left - 1'b1;
                    if (left == NB_W'(1)) begin
                        busy_o <= 1'b0;
                        fin_o  <= 1'b1;
                        mosi_o <= 1'b0;
                    end else begin
                        sreg   <= sreg << 1;
                        mosi_o <= sreg[XFER_W-2];
                    end
                end
            end
        end
    end

    // R9: the engine rests with SCK and MOSI low between transfers.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sck_o && !mosi_o));
    // R9: a running transfer always has bits left to send.
    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (left != '0));
endmodule

// File: rtl/eeprom_page_writer.sv
// Paged serial-EEPROM word writer. It checks the request, then runs one burst
// per page: status polling with a retry budget, write-enable, then the write
// opcode with the byte address and the byte-swapped words, then the
// write-cycle wait. Assumes OP_BITS <= 8, OFF_W and CNT_W >= IDX_W, and
// PAGE_BYTES even. Timing counts are in clock cycles.
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int DEV_WORDS  = 256,
    parameter int OP_BITS    = 8,
    parameter int ADDR_BITS  = 8,
    parameter int PAGE_BYTES = 16,
    parameter int RETRY_MAX  = 3,
    parameter int WCYC_CLKS  = 20,
    parameter int HALF_CLKS  = 1,
    parameter int OFF_W      = 10,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [15:0]      wdata_i,
    input  logic             wvalid_i,
    output logic             wready_o,
    output logic             spi_cs_n_o,
    output logic             spi_sck_o,
    output logic             spi_mosi_o,
    input  logic             spi_miso_i,
    output logic             done_o,
    output logic             err_o
);
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int IDX_W      = $clog2(DEV_WORDS) + 1;
    localparam int BA_W       = IDX_W + 1;
    localparam int CMD_BITS   = OP_BITS + ADDR_BITS;
    localparam int XFER_W     = (CMD_BITS > 16) ? CMD_BITS : 16;
    localparam int NB_W       = $clog2(XFER_W + 1);
    localparam int TRY_W      = $clog2(RETRY_MAX + 1);
    localparam int TMAX       = (WCYC_CLKS > HALF_CLKS) ? WCYC_CLKS : HALF_CLKS;
    localparam int TMR_W      = $clog2(TMAX + 1);
    localparam bit FOLD_HI    = (ADDR_BITS == 8);

    localparam logic [OP_BITS-1:0] OPC_STATUS = OP_BITS'(EPW_OP_STATUS);
    localparam logic [OP_BITS-1:0] OPC_WREN   = OP_BITS'(EPW_OP_WREN);
    localparam logic [OP_BITS-1:0] OPC_WRITE  = OP_BITS'(EPW_OP_WRITE);
    localparam logic [OP_BITS-1:0] OPC_HI     = OP_BITS'(EPW_OP_HI_ADDR);

    epw_state_e        st;
    epw_cmd_e          nxt;
    logic [IDX_W-1:0]  cur, left, cur_nx;
    logic [TRY_W-1:0]  tries;
    logic [TMR_W-1:0]  tmr;
    logic              cs_n_q, go_q, done_q, err_q;
    logic [NB_W-1:0]   go_bits;
    logic [XFER_W-1:0] go_data;
    logic              range_ok, eng_busy, eng_fin, eng_sck, eng_mosi;
    logic [7:0]        eng_din;
    logic [BA_W-1:0]   byte_addr;
    logic              hi_bit, page_end;
    logic [OP_BITS-1:0]  wr_op;
    logic [XFER_W-1:0]   poll_word, wren_word, wrcmd_word, data_word;

    epw_range_check #(.DEV_WORDS(DEV_WORDS), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_range (
        .offset_i(offset_i), .count_i(count_i), .ok_o(range_ok));

    epw_shift_engine #(.XFER_W(XFER_W), .HALF_CLKS(HALF_CLKS)) u_engine (
        .clk(clk), .rst_n(rst_n), .go_i(go_q), .nbits_i(go_bits),
        .dout_i(go_data), .miso_i(spi_miso_i), .busy_o(eng_busy),
        .fin_o(eng_fin), .din_o(eng_din), .sck_o(eng_sck), .mosi_o(eng_mosi));

    // Byte address of the current word and the page-end test after it.
    assign byte_addr = {cur, 1'b0};
    assign cur_nx    = cur + 1'b1;
    assign page_end  = (cur_nx % IDX_W'(PAGE_WORDS)) == '0;

    // Small parts carry the address bit above the field inside the opcode.
    generate
        if (FOLD_HI) begin : g_fold
            assign hi_bit = byte_addr[ADDR_BITS];
        end else begin : g_nofold
            assign hi_bit = 1'b0;
        end
    endgenerate

    // Command words, right-aligned; the engine sends the low bits MSB first.
    always_comb begin
        wr_op      = OPC_WRITE | (hi_bit ? OPC_HI : '0);
        poll_word  = XFER_W'({OPC_STATUS, 8'h00});
        wren_word  = XFER_W'(OPC_WREN);
        wrcmd_word = XFER_W'({wr_op, byte_addr[ADDR_BITS-1:0]});
        data_word  = XFER_W'({wdata_i[7:0], wdata_i[15:8]});
    end

    // Main sequencer: bounds, polling, enable, write frame, write-cycle wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; nxt <= K_POLL; cur <= '0; left <= '0; tries <= '0;
            tmr <= '0; cs_n_q <= 1'b1; go_q <= 1'b0; done_q <= 1'b0;
            err_q <= 1'b0; go_bits <= '0; go_data <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (start_i) begin
                    if (!range_ok) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        cur     <= IDX_W'(offset_i);
                        left    <= IDX_W'(count_i);
                        tries   <= '0;
                        err_q   <= 1'b0;
                        cs_n_q  <= 1'b0;
                        go_q    <= 1'b1;
                        go_bits <= NB_W'(OP_BITS + 8);
                        go_data <= poll_word;
                        st      <= S_POLL;
                    end
                end
                S_POLL: if (eng_fin) begin
                    cs_n_q <= 1'b1;
                    tmr    <= '0;
                    if (!eng_din[0]) begin
                        nxt <= K_WREN;
                        st  <= S_GAP;
                    end else if (tries == TRY_W'(RETRY_MAX - 1)) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        tries <= tries + 1'b1;
                        nxt   <= K_POLL;
                        st    <= S_GAP;
                    end
                end
                S_GAP: if (tmr == TMR_W'(HALF_CLKS - 1)) begin
                    cs_n_q <= 1'b0;
                    go_q   <= 1'b1;
                    case (nxt)
                        K_POLL: begin
                            go_bits <= NB_W'(OP_BITS + 8); go_data <= poll_word;
                            st <= S_POLL;
                        end
                        K_WREN: begin
                            go_bits <= NB_W'(OP_BITS); go_data <= wren_word;
                            st <= S_WREN;
                        end
                        default: begin
                            go_bits <= NB_W'(CMD_BITS); go_data <= wrcmd_word;
                            st <= S_WRCMD;
                        end
                    endcase
                end else begin
                    tmr <= tmr + 1'b1;
                end
                S_WREN: if (eng_fin) begin
                    cs_n_q <= 1'b1;
                    tmr    <= '0;
                    nxt    <= K_WRCMD;
                    st     <= S_GAP;
                end
                S_WRCMD: if (eng_fin) st <= S_WAIT_W;
                S_WAIT_W: if (wvalid_i) begin
                    go_q    <= 1'b1;
                    go_bits <= NB_W'(16);
                    go_data <= data_word;
                    st      <= S_DATA;
                end
                S_DATA: if (eng_fin) begin
                    cur  <= cur_nx;
                    left <= left - 1'b1;
                    if (left == IDX_W'(1) || page_end) begin
                        cs_n_q <= 1'b1;
                        tmr    <= '0;
                        st     <= S_WCYC;
                    end else begin
                        st <= S_WAIT_W;
                    end
                end
                S_WCYC: if (tmr == TMR_W'(WCYC_CLKS - 1)) begin
                    if (left == '0) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        tries   <= '0;
                        cs_n_q  <= 1'b0;
                        go_q    <= 1'b1;
                        go_bits <= NB_W'(OP_BITS + 8);
                        go_data <= poll_word;
                        st      <= S_POLL;
                    end
                end else begin
                    tmr <= tmr + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign wready_o   = (st == S_WAIT_W);
    assign spi_cs_n_o = cs_n_q;
    assign spi_sck_o  = eng_sck;
    assign spi_mosi_o = eng_mosi;
    assign done_o     = done_q;
    assign err_o      = err_q;

    // R1: an out-of-range request ends with done and error on the next cycle.
    a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start_i && !range_ok) |=> (done_o && err_o));
    // R3: the poll counter never passes the retry budget.
    a_r3_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tries) < RETRY_MAX));
    // R9: SCK pulses only inside a selected frame.
    a_r9_sck_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck_o |-> !spi_cs_n_o);
    // R10: chip select stays high through the write-cycle wait.
    a_r10_wait_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WCYC) |-> spi_cs_n_o);
    // R11: done lasts a single cycle.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R11: words are taken only inside a selected write frame.
    a_r11_ready_selected: assert property (@(posedge clk) disable iff (!rst_n)
        wready_o |-> (!spi_cs_n_o && !eng_busy));
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
    localparam int DEV_WORDS  = 256;
    localparam int ADDR_BITS  = 8;
    localparam int PAGE_BYTES = 16;
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int RETRY_MAX  = 3;
    localparam int WCYC_CLKS  = 20;
    localparam int HALF_CLKS  = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start_i, wvalid_i, wready_o;
    logic [9:0]  offset_i, count_i;
    logic [15:0] wdata_i;
    logic        spi_cs_n_o, spi_sck_o, spi_mosi_o, done_o, err_o;
    logic        spi_miso_i = 1'b0;

    eeprom_page_writer #(
        .DEV_WORDS(DEV_WORDS), .OP_BITS(8), .ADDR_BITS(ADDR_BITS),
        .PAGE_BYTES(PAGE_BYTES), .RETRY_MAX(RETRY_MAX), .WCYC_CLKS(WCYC_CLKS),
        .HALF_CLKS(HALF_CLKS), .OFF_W(10), .CNT_W(10)
    ) i_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
        .count_i(count_i), .wdata_i(wdata_i), .wvalid_i(wvalid_i),
        .wready_o(wready_o), .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o),
        .spi_mosi_o(spi_mosi_o), .spi_miso_i(spi_miso_i), .done_o(done_o),
        .err_o(err_o));

    int n_tests = 0, n_fail = 0, cyc = 0;

    function automatic logic [15:0] word_fn(int i);
        return 16'hC3A5 ^ 16'(i * 403);
    endfunction

    // Word source: every accepted word advances the index.
    int widx = 0;
    assign wdata_i = word_fn(widx);
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (wvalid_i && wready_o) widx <= widx + 1;
    end

    // Memory model at the pins.
    logic [255:0] fr_bits [128];
    int           fr_len  [128];
    int           fr_n = 0;
    logic [255:0] cur_bits;
    int           cur_len = 0, fall_n = 0;
    logic [7:0]   cur_op = 8'h00;
    int busy_left = 0, busy_reload = 0;
    bit armed = 1'b0, last_write = 1'b0;
    int wr_end = 0, sck_bad = 0, mosi_bad = 0, gap_bad = 0;

    always @(negedge spi_cs_n_o) if (armed) begin
        cur_bits = '0; cur_len = 0; fall_n = 0; cur_op = 8'h00; spi_miso_i = 1'b0;
        if (spi_sck_o) sck_bad++;
        if (last_write && (cyc - wr_end) < WCYC_CLKS) gap_bad++;
        last_write = 1'b0;
    end

    always @(posedge spi_sck_o) if (armed && !spi_cs_n_o) begin
        cur_bits = {cur_bits[254:0], spi_mosi_o};
        cur_len++;
        if (cur_len == 8) cur_op = cur_bits[7:0];
    end

    always @(negedge spi_sck_o) if (armed && !spi_cs_n_o) begin
        logic [7:0] stat;
        fall_n++;
        stat = (busy_left > 0) ? 8'h01 : 8'hFE;
        if (cur_op == 8'h05 && fall_n >= 8 && fall_n <= 15) spi_miso_i = stat[15 - fall_n];
        else spi_miso_i = 1'b0;
    end

    always @(spi_mosi_o) if (armed && !spi_cs_n_o && spi_sck_o) mosi_bad++;

    always @(posedge spi_cs_n_o) if (armed && cur_len > 0) begin
        if (spi_mosi_o) mosi_bad++;
        if (spi_sck_o) sck_bad++;
        if (fr_n < 128) begin
            fr_bits[fr_n] = cur_bits;
            fr_len[fr_n]  = cur_len;
            fr_n++;
        end
        if (cur_op == 8'h05 && busy_left > 0) busy_left--;
        if ((cur_op & 8'hF7) == 8'h02 && cur_len > 8) begin
            busy_left  = busy_reload;
            last_write = 1'b1;
            wr_end     = cyc;
        end
        cur_len = 0;
    end

    // Expected frames.
    logic [255:0] ex_bits [128];
    int           ex_len  [128];
    int           ex_n = 0;

    task automatic push_frame(logic [255:0] b, int l);
        ex_bits[ex_n] = b; ex_len[ex_n] = l; ex_n++;
    endtask

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_txn(int off, int cnt, int busy);
        bit legal, exp_err;
        int cur, rem, t, polls;
        logic [255:0] b;
        int l;
        string tag;
        legal   = (off < DEV_WORDS) && (cnt != 0) && (cnt <= DEV_WORDS - off);
        exp_err = !legal;
        ex_n    = 0;
        if (legal) begin
            cur = off; rem = cnt;
            while (rem > 0 && !exp_err) begin
                polls = (busy >= RETRY_MAX) ? RETRY_MAX : busy + 1;
                for (int p = 0; p < polls; p++) push_frame(256'h0500, 16);
                if (busy >= RETRY_MAX) begin
                    exp_err = 1'b1;
                end else begin
                    push_frame(256'h06, 8);
                    b = 256'(8'h02 | ((cur >= 128) ? 8'h08 : 8'h00));
                    b = (b << 8) | 256'((2 * cur) & 255);
                    l = 16;
                    do begin
                        b = (b << 16) | 256'({word_fn(cur)[7:0], word_fn(cur)[15:8]});
                        l += 16; cur++; rem--;
                    end while (rem > 0 && (cur % PAGE_WORDS) != 0);
                    push_frame(b, l);
                end
            end
        end
        @(negedge clk);
        fr_n = 0; busy_left = busy; busy_reload = busy; last_write = 1'b0;
        widx = off; offset_i = 10'(off); count_i = 10'(cnt); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 0;
        while (!done_o && t < 30000) begin @(negedge clk); t++; end
        tag = !legal ? "R1" : (busy >= RETRY_MAX) ? "R3" : "R11";
        check(done_o, tag, $sformatf("done seen off=%0d cnt=%0d", off, cnt), done_o, 1);
        check(err_o == exp_err, tag, $sformatf("error off=%0d cnt=%0d busy=%0d", off, cnt, busy), err_o, exp_err);
        check(!last_write || (cyc - wr_end) >= WCYC_CLKS, "R10", "wait before done", cyc - wr_end, WCYC_CLKS);
        check(fr_n == ex_n, (busy >= RETRY_MAX) ? "R3" : "R8",
              $sformatf("frame count off=%0d cnt=%0d", off, cnt), fr_n, ex_n);
        begin
            bit same = 1'b1;
            int bad = 0;
            for (int i = 0; i < ex_n && i < fr_n; i++)
                if (same && (fr_bits[i] !== ex_bits[i] || fr_len[i] != ex_len[i])) begin
                    same = 1'b0; bad = i;
                end
            if (same) check(1'b1, "R7", "frames", 0, 0);
            else begin
                int le = ex_len[bad];
                logic [7:0] eo, ao, ea, aa;
                eo = 8'(ex_bits[bad] >> (le - 8));  ao = 8'(fr_bits[bad] >> (le - 8));
                ea = 8'(ex_bits[bad] >> (le - 16)); aa = 8'(fr_bits[bad] >> (le - 16));
                if (le == 16 && ex_bits[bad][15:8] == 8'h05) tag = "R2";
                else if (le == 8) tag = "R4";
                else if (ao != eo) tag = "R5";
                else if (aa != ea) tag = "R6";
                else if (fr_len[bad] != le) tag = "R8";
                else tag = "R7";
                check(1'b0, tag, $sformatf("frame %0d off=%0d cnt=%0d len %0d/%0d bits %0h",
                      bad, off, cnt, fr_len[bad], le, fr_bits[bad][63:0]),
                      int'(fr_bits[bad][31:0]), int'(ex_bits[bad][31:0]));
            end
        end
        check((widx - off) == (exp_err ? ((legal && busy < RETRY_MAX) ? cnt : 0) : cnt),
              "R11", "words consumed", widx - off, exp_err ? 0 : cnt);
        @(negedge clk);
        check(!done_o && spi_cs_n_o && !wready_o, "R11", "idle after done",
              {done_o, spi_cs_n_o, wready_o}, 3'b010);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL R11 watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int offs[13] = '{0, 5, 7, 8, 120, 126, 127, 128, 129, 250, 255, 256, 300};
        int cnts[6]  = '{0, 1, 2, 8, 9, 17};
        rst_n = 1'b0; start_i = 1'b0; wvalid_i = 1'b0; offset_i = '0; count_i = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;
        @(negedge clk);
        check(spi_cs_n_o && !spi_sck_o && !spi_mosi_o && !done_o && !wready_o,
              "R11", "reset state", {spi_cs_n_o, spi_sck_o, spi_mosi_o, done_o, wready_o}, 5'b10000);
        wvalid_i = 1'b1;
        foreach (offs[i]) foreach (cnts[j]) run_txn(offs[i], cnts[j], 0);
        run_txn(0, 256, 0);
        run_txn(126, 4, 1);
        run_txn(3, 3, 2);
        run_txn(255, 1, 1);
        run_txn(130, 2, 3);
        run_txn(10, 5, 5);
        check(sck_bad == 0, "R9", "SCK low at chip-select edges", sck_bad, 0);
        check(mosi_bad == 0, "R9", "MOSI stable while SCK high and low at end", mosi_bad, 0);
        check(gap_bad == 0, "R10", "write-cycle gap before next frame", gap_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule